// File: doc/BRIEF.md
# Dual Register-Mapped Timer/Counter

This peripheral holds two independent timer/counters behind a small 32-bit register port. Each timer has three word registers: a control/status word, a load value and a live counter. Software programs the load value, pulses the load bit to copy it into the counter, and then enables the timer. It counts up or down once per clock and, at its terminal value, either reloads itself for periodic operation or stops and holds.

Each timer keeps its own sticky interrupt flag. The flag is cleared by writing a 1 to it, so the word just read can be written back as an acknowledge. One interrupt line is the OR of every timer whose flag and interrupt-enable bit are both set. An enable-all bit in either control word starts both timers in the same cycle. The mode, output-enable, capture-enable and PWM bits are stored and read back but have no effect on counting.

Top module: `dual_timer_counter`

## Requirements
- R1: Word registers sit at byte offsets 0x00 control/status, 0x04 load, 0x08 counter for timer 0, and 0x10, 0x14, 0x18 for timer 1. Reads of other offsets return 0. Writes to the counter offsets are ignored. Reads are combinational.
- R2: Control word bits are: 0 mode, 1 direction (1 = down), 2 output enable, 3 capture enable, 4 auto-reload, 5 load, 6 interrupt enable, 7 timer enable, 8 interrupt status, 9 PWM enable, 10 enable-all. Bits 31..11 read as 0. Bits 0, 2, 3, 9 and 10 read back as written.
- R3: While the load bit is set, the counter takes the load register value on every clock. This overrides counting even when the timer enable bit is set.
- R4: A down-counting enabled timer whose counter is 0 expires on the next clock. Expiry sets the status bit. With auto-reload set, the counter returns to the load value, so the period is load+1 clocks.
- R5: An up-counting enabled timer adds 1 each clock and expires when its counter is 0xFFFFFFFF. With auto-reload set and a load value of 0, it acts as a free-running counter.
- R6: At expiry without auto-reload, the counter holds its value and the timer enable bit clears.
- R7: Writing 1 to the status bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the bit set.
- R8: A timer whose enable bit is 0 keeps its counter frozen. Clearing only the enable bit changes no other control bit.
- R9: The interrupt output is 1 exactly when some timer has both its status bit and its interrupt-enable bit set.
- R10: A control write with bit 10 set, to either timer, sets the enable bit of both timers in that cycle.
- R11: Reset clears every register and deasserts the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Byte address; word-aligned accesses only |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the clock edge that samples it. A read of that register is valid in the same low phase after the edge. The counter moves one step per edge. It lags by one edge when a control write sets the load bit or the enable bit, because counting uses the control value held before the edge. For a load value L, a down-counting periodic timer therefore reaches 0 four edges after a start write with L=4, and it raises the status bit and the interrupt on the fifth edge. The bench drives on falling edges, counts falling edges between steps, and compares each read against these edge counts. One directed case places a clearing write on the exact expiry edge.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int CTRL_W   = 11;
  localparam int B_MODE   = 0;
  localparam int B_DOWN   = 1;
  localparam int B_GENOUT = 2;
  localparam int B_CAPT   = 3;
  localparam int B_RELOAD = 4;
  localparam int B_LOAD   = 5;
  localparam int B_IE     = 6;
  localparam int B_EN     = 7;
  localparam int B_STAT   = 8;
  localparam int B_PWM    = 9;
  localparam int B_ALL    = 10;
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_LOAD  = 2'd1;
  localparam logic [1:0] REG_COUNT = 2'd2;
endpackage

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              load_wr,
  input  logic              force_en,
  input  logic [W-1:0]      wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      load_o,
  output logic [W-1:0]      count_o,
  output logic              expire_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [W-1:0]      load_q, count_q;
  logic              hold_ld, run, down, reload;

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic dn);
    return dn ? c - W'(1) : c + W'(1);
  endfunction

  function automatic logic at_terminal(input logic [W-1:0] c, input logic dn);
    return dn ? (c == '0) : (c == ALL_ONES);
  endfunction

  assign hold_ld  = ctrl_q[B_LOAD];
  assign run      = ctrl_q[B_EN];
  assign down     = ctrl_q[B_DOWN];
  assign reload   = ctrl_q[B_RELOAD];
  assign expire_o = !hold_ld && run && at_terminal(count_q, down);

  always_comb begin
    ctrl_d = ctrl_q;
    if (csr_wr) begin
      ctrl_d         = wdata[CTRL_W-1:0];
      ctrl_d[B_STAT] = ctrl_q[B_STAT] & ~wdata[B_STAT];
    end else if (expire_o && !reload) begin
      ctrl_d[B_EN] = 1'b0;
    end
    if (expire_o) ctrl_d[B_STAT] = 1'b1;
    if (force_en) ctrl_d[B_EN] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      count_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (load_wr) load_q <= wdata;
      if (hold_ld) begin
        count_q <= load_q;
      end else if (run) begin
        if (expire_o) begin
          if (reload) count_q <= load_q;
        end else begin
          count_q <= step(count_q, down);
        end
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign count_o = count_q;
endmodule

// File: rtl/dtc_irq.sv
module dtc_irq #(
  parameter int N = 2
) (
  input  logic [N-1:0] status,
  input  logic [N-1:0] ie,
  output logic         irq
);
  assign irq = |(status & ie);
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import dtc_pkg::*;
#(
  parameter  int W      = 32,
  parameter  int N_TMR  = 2,
  localparam int BANK_W = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int ADDR_W = 4 + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_out
);
  logic [BANK_W-1:0] bank;
  logic [1:0]        regsel;
  logic              aligned, any_all_set;

  logic [N_TMR-1:0][CTRL_W-1:0] tmr_ctrl;
  logic [N_TMR-1:0][W-1:0]      tmr_load, tmr_count;
  logic [N_TMR-1:0] tmr_expire, tmr_csr_wr, tmr_load_wr;
  logic [N_TMR-1:0] tmr_en, tmr_ld, tmr_ie, tmr_status, tmr_reload;

  assign bank        = bus_addr[ADDR_W-1:4];
  assign regsel      = bus_addr[3:2];
  assign aligned     = (bus_addr[1:0] == 2'b00) && (int'(bank) < N_TMR);
  assign any_all_set = bus_wr && aligned && (regsel == REG_CTRL) && bus_wdata[B_ALL];

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign tmr_csr_wr[i]  = bus_wr && aligned && (int'(bank) == i) && (regsel == REG_CTRL);
    assign tmr_load_wr[i] = bus_wr && aligned && (int'(bank) == i) && (regsel == REG_LOAD);

    dtc_channel #(.W(W)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .csr_wr   (tmr_csr_wr[i]),
      .load_wr  (tmr_load_wr[i]),
      .force_en (any_all_set),
      .wdata    (bus_wdata),
      .ctrl_o   (tmr_ctrl[i]),
      .load_o   (tmr_load[i]),
      .count_o  (tmr_count[i]),
      .expire_o (tmr_expire[i])
    );

    assign tmr_en[i]     = tmr_ctrl[i][B_EN];
    assign tmr_ld[i]     = tmr_ctrl[i][B_LOAD];
    assign tmr_ie[i]     = tmr_ctrl[i][B_IE];
    assign tmr_status[i] = tmr_ctrl[i][B_STAT];
    assign tmr_reload[i] = tmr_ctrl[i][B_RELOAD];
  end

  dtc_irq #(.N(N_TMR)) i_irq (
    .status (tmr_status),
    .ie     (tmr_ie),
    .irq    (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (regsel)
        REG_CTRL:  bus_rdata = W'(tmr_ctrl[bank]);
        REG_LOAD:  bus_rdata = tmr_load[bank];
        REG_COUNT: bus_rdata = tmr_count[bank];
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int W = 32,
  parameter int N = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              any_all_set,
  input logic              irq_out,
  input logic [N-1:0]      tmr_expire,
  input logic [N-1:0]      tmr_en,
  input logic [N-1:0]      tmr_ld,
  input logic [N-1:0]      tmr_ie,
  input logic [N-1:0]      tmr_status,
  input logic [N-1:0]      tmr_reload,
  input logic [N-1:0][W-1:0] tmr_load,
  input logic [N-1:0][W-1:0] tmr_count
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    p_load_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ld[i] |=> (tmr_count[i] == $past(tmr_load[i])));
    p_expire_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire[i] |=> tmr_status[i]);
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_expire[i] && !tmr_reload[i] && !bus_wr) |=> !tmr_en[i]);
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en[i] && !tmr_ld[i]) |=> $stable(tmr_count[i]));
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_status[i] && tmr_ie[i]) |-> irq_out);
    p_enable_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any_all_set |=> tmr_en[i]);
  end
endmodule

bind dual_timer_counter dtc_checker #(.W(W), .N(N_TMR)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .any_all_set (any_all_set),
  .irq_out     (irq_out),
  .tmr_expire  (tmr_expire),
  .tmr_en      (tmr_en),
  .tmr_ld      (tmr_ld),
  .tmr_ie      (tmr_ie),
  .tmr_status  (tmr_status),
  .tmr_reload  (tmr_reload),
  .tmr_load    (tmr_load),
  .tmr_count   (tmr_count)
);

// File: tb/test_dual_timer_counter.sv
module test_dual_timer_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int          n_checks = 0;
  int          n_errors = 0;

  dual_timer_counter i_dual_timer_counter (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // {address, write data, expected readback}
  localparam logic [68:0] VEC [7] = '{
    {5'h04, 32'h0000_1234, 32'h0000_1234},  // R1 load0
    {5'h14, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R1 load1
    {5'h00, 32'hFFFF_F20D, 32'h0000_020D},  // R2 inert bits kept, upper bits 0
    {5'h08, 32'h0000_5555, 32'h0000_0000},  // R1 counter write ignored
    {5'h00, 32'h0000_0000, 32'h0000_0000},  // R2
    {5'h10, 32'h0000_0100, 32'h0000_0000},  // R7 clearing an idle flag
    {5'h0C, 32'h0000_FFFF, 32'h0000_0000}   // R1 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    rd(5'h00, v); check("R11 ctrl0", v, 0);
    rd(5'h18, v); check("R11 count1", v, 0);
    check("R11 irq", 32'(irq_out), 0);

    for (int k = 0; k < 7; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rd(VEC[k][68:64], v);
      check("R1/R2 vector", v, VEC[k][31:0]);
    end

    // R3/R4 periodic down count, load 4
    wr(5'h04, 32'd4);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'h1D2);
    rd(5'h08, v); check("R3 counter loaded", v, 4);
    tick(4);
    rd(5'h08, v); check("R4 reached zero", v, 0);
    check("R9 irq before expiry", 32'(irq_out), 0);
    tick(1);
    rd(5'h08, v); check("R4 reloaded", v, 4);
    check("R9 irq after expiry", 32'(irq_out), 1);
    rd(5'h00, v); check("R4 status set", v, 32'h1D2);
    wr(5'h00, v);
    rd(5'h00, v); check("R7 write-back clears", v, 32'h0D2);
    check("R9 irq acked", 32'(irq_out), 0);
    rd(5'h08, v); check("R4 counting on", v, 3);
    tick(3);
    wr(5'h00, 32'h1D2);  // clear lands on the expiry edge
    rd(5'h00, v); check("R7 set wins over clear", v, 32'h1D2);
    rd(5'h08, v); check("R4 period L+1", v, 4);

    // R8 stop only the enable bit
    wr(5'h00, 32'h052);
    rd(5'h08, v);
    tick(3);
    begin
      logic [31:0] v2;
      rd(5'h08, v2); check("R8 counter frozen", v2, v);
    end
    rd(5'h00, v); check("R8 other bits kept", v, 32'h152);
    wr(5'h00, 32'h012);
    check("R9 masked by ie", 32'(irq_out), 0);
    rd(5'h00, v); check("R9 flag still set", v, 32'h112);
    wr(5'h00, 32'h100);
    rd(5'h00, v); check("R7 cleared", v, 0);

    // R5/R6 up count without reload on timer 1
    wr(5'h14, 32'hFFFF_FFFD);
    wr(5'h10, 32'h20);
    wr(5'h10, 32'h80);
    rd(5'h18, v); check("R5 start", v, 32'hFFFF_FFFD);
    tick(2);
    rd(5'h18, v); check("R5 at top", v, 32'hFFFF_FFFF);
    rd(5'h10, v); check("R5 no flag yet", v, 32'h080);
    tick(1);
    rd(5'h10, v); check("R6 enable cleared, flag set", v, 32'h100);
    tick(2);
    rd(5'h18, v); check("R6 counter holds", v, 32'hFFFF_FFFF);
    check("R9 no irq without ie", 32'(irq_out), 0);
    wr(5'h10, 32'h20);
    rd(5'h10, v); check("R7 write 0 keeps flag", v, 32'h120);

    // R5 free-running with reload from 0
    wr(5'h14, 32'h0);
    wr(5'h10, 32'h90);
    rd(5'h18, v); check("R5 free-run start", v, 0);
    tick(5);
    rd(5'h18, v); check("R5 free-run count", v, 5);
    wr(5'h10, 32'h10);
    rd(5'h10, v); check("R8 timer1 stopped", v, 32'h110);

    // R10 enable-all from timer 0's word
    wr(5'h04, 32'd10);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'h02);
    tick(2);
    rd(5'h08, v); check("R8 disabled hold", v, 10);
    wr(5'h00, 32'h402);
    rd(5'h00, v); check("R10 ctrl0 enabled", v, 32'h482);
    rd(5'h10, v); check("R10 ctrl1 enabled", v, 32'h190);
    rd(5'h08, v); check("R10 count0 before", v, 10);
    tick(1);
    rd(5'h08, v); check("R10 count0 running", v, 9);

    // R3 load overrides enable
    wr(5'h00, 32'h0A2);
    tick(3);
    rd(5'h08, v); check("R3 load beats enable", v, 10);

    summary();
    $finish;
  end
endmodule